// File: doc/BRIEF.md
# Configurable Registered Fan-out Buffer

This block is a bank of clocked flip-flops that sits between a memory controller and a set of memory devices. Every rising clock edge it takes in up to 25 data channels and three control lines (a chip select, an on-die termination enable and a clock enable) and presents them as registered outputs. Two static configuration inputs choose the layout. In the wide layout all channels are passed 1:1. In the split layout 14 channel slots are registered once and each drives an A copy and a B copy, and one of two channel mappings is selected.

A pair of select inputs gates the ordinary data outputs: when both are HIGH at an edge, the data outputs keep their value. The chip-select, termination and clock-enable outputs always register. An active-low reset clears every output at once without a clock. Its release passes through a two-stage synchronizer, so the outputs cannot move until normal capture resumes on a later edge. Channel n is carried on bit n-1 of `d_in` and `q_a`, and on bit n-1 of `q_b`.

Top module: `cfgbuf`

## Requirements
- R1: While `rst_n` is LOW, every output is LOW, and this takes effect as soon as `rst_n` falls, with no clock edge needed.
- R2: After `rst_n` rises, every output stays LOW through the first and second rising clock edges, whatever the inputs are. The first capture of inputs happens on the third rising edge.
- R3: At a rising edge where `sel_dram` or `sel_reg` is LOW, every active bit of `q_a` loads the `d_in` bit of the same index (channel n on bit n-1).
- R4: At a rising edge where `sel_dram` and `sel_reg` are both HIGH, `q_a` and `q_b` keep their previous values.
- R5: At every rising edge, `cs_a` loads `sel_dram`, and `odt_a` and `cke_a` load their selected sources, whatever the state of the selects.
- R6: Wide layout (`cfg_split` LOW, `cfg_alt` either value): the active channels are 2, 3, 5, 6 and 8 to 25. `q_a` bits 0, 3 and 6 and every `_b` output are LOW. Termination and clock enable come from `odt_in` and `cke_in`.
- R7: Split layout A (`cfg_split` HIGH, `cfg_alt` LOW): the active channels are 2, 3, 5, 6 and 8 to 14. `q_a` bits 0, 3, 6 and 14 to 24 are LOW. Every `_b` output equals its `_a` output.
- R8: Split layout B (both HIGH): the active channels are 1 to 6, 8 to 10, 12 and 13. Termination is taken from `d_in[10]` (channel 11) and clock enable from `d_in[13]` (channel 14), and `odt_in` and `cke_in` have no effect. `q_a` bits 6, 10 and 13 to 24 are LOW. Every `_b` output equals its `_a` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | LOW: wide 1:1 layout, HIGH: split 1:2 layout |
| cfg_alt | input | 1 | Selects mapping B in split layout |
| sel_dram | input | 1 | First select; also the source for the chip-select output |
| sel_reg | input | 1 | Second select; gates data together with `sel_dram` |
| odt_in | input | 1 | Termination enable input (wide and split A) |
| cke_in | input | 1 | Clock enable input (wide and split A) |
| d_in | input | 25 | Data channels, channel n on bit n-1 |
| q_a | output | 25 | Registered data, A copy |
| q_b | output | 14 | Registered data, B copy (split layout only) |
| cs_a | output | 1 | Registered chip select, A copy |
| cs_b | output | 1 | Registered chip select, B copy |
| odt_a | output | 1 | Registered termination enable, A copy |
| odt_b | output | 1 | Registered termination enable, B copy |
| cke_a | output | 1 | Registered clock enable, A copy |
| cke_b | output | 1 | Registered clock enable, B copy |

## Verification
The properties assume that `cfg_split` and `cfg_alt` change only while `rst_n` is LOW, and that `rst_n` never moves at the same instant as a rising clock edge. The stimulus changes data and selects one nanosecond after a falling edge. It changes the layout only inside a reset window. It asserts and releases reset at randomly chosen phases that keep clear of both clock edges, which covers the capture timing after release without depending on process order at an edge.

// File: rtl/cfgbuf_pkg.sv
package cfgbuf_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    LAYOUT_WIDE    = 2'd0,
    LAYOUT_SPLIT_A = 2'd1,
    LAYOUT_SPLIT_B = 2'd2
  } layout_e;

  // Channels left unused in the wide layout and in split mapping A.
  localparam int unsigned GAP_CH_0 = 1;
  localparam int unsigned GAP_CH_1 = 4;
  localparam int unsigned GAP_CH_2 = 7;

  // A split-mode low select gives the wide layout.
  function automatic layout_e decode_layout(input logic split, input logic alt);
    layout_e l;
    if (!split)   l = LAYOUT_WIDE;
    else if (alt) l = LAYOUT_SPLIT_B;
    else          l = LAYOUT_SPLIT_A;
    return l;
  endfunction

  function automatic logic is_gap(input int unsigned ch);
    return (ch == GAP_CH_0) || (ch == GAP_CH_1) || (ch == GAP_CH_2);
  endfunction
endpackage

// File: rtl/cfgbuf_rst_sync.sv
module cfgbuf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfgbuf_route.sv
module cfgbuf_route
  import cfgbuf_pkg::*;
#(
  parameter int unsigned NUM_CH     = 25,
  parameter int unsigned NUM_DUP    = 14,
  parameter int unsigned ODT_ALT_CH = 11,
  parameter int unsigned CKE_ALT_CH = 14
) (
  input  layout_e           layout,
  input  logic [NUM_CH-1:0] d_in,
  input  logic              odt_in,
  input  logic              cke_in,
  output logic [NUM_CH-1:0] d_sel,
  output logic              odt_sel,
  output logic              cke_sel,
  output logic              dup_en
);
  timeunit 1ns;
  timeprecision 1ps;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    localparam int unsigned CH     = gi + 1;
    localparam logic        ON_W   = !is_gap(CH);
    localparam logic        ON_A   = (CH <= NUM_DUP) && !is_gap(CH);
    localparam logic        ON_B   = (CH <= NUM_DUP - 1) && (CH != GAP_CH_2) &&
                                     (CH != ODT_ALT_CH);
    logic active;

    always_comb begin
      unique case (layout)
        LAYOUT_SPLIT_A: active = ON_A;
        LAYOUT_SPLIT_B: active = ON_B;
        default:        active = ON_W;
      endcase
    end

    assign d_sel[gi] = d_in[gi] & active;
  end

  always_comb begin
    odt_sel = odt_in;
    cke_sel = cke_in;
    if (layout == LAYOUT_SPLIT_B) begin
      odt_sel = d_in[ODT_ALT_CH-1];
      cke_sel = d_in[CKE_ALT_CH-1];
    end
  end

  assign dup_en = (layout != LAYOUT_WIDE);
endmodule

// File: rtl/cfgbuf_bank.sv
module cfgbuf_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/cfgbuf_fanout.sv
module cfgbuf_fanout #(
  parameter int unsigned NUM_CH  = 25,
  parameter int unsigned NUM_DUP = 14,
  parameter int unsigned NUM_CTL = 3
) (
  input  logic               dup_en,
  input  logic [NUM_CH-1:0]  data_r,
  input  logic [NUM_CTL-1:0] ctl_r,
  output logic [NUM_CH-1:0]  data_a,
  output logic [NUM_DUP-1:0] data_b,
  output logic [NUM_CTL-1:0] ctl_a,
  output logic [NUM_CTL-1:0] ctl_b
);
  timeunit 1ns;
  timeprecision 1ps;

  assign data_a = data_r;
  assign ctl_a  = ctl_r;

  for (genvar gi = 0; gi < NUM_DUP; gi++) begin : g_dup
    assign data_b[gi] = dup_en & data_r[gi];
  end

  for (genvar gc = 0; gc < NUM_CTL; gc++) begin : g_ctl
    assign ctl_b[gc] = dup_en & ctl_r[gc];
  end
endmodule

// File: rtl/cfgbuf.sv
module cfgbuf
  import cfgbuf_pkg::*;
#(
  parameter int unsigned NUM_CH      = 25,
  parameter int unsigned NUM_DUP     = 14,
  parameter int unsigned ODT_ALT_CH  = 11,
  parameter int unsigned CKE_ALT_CH  = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_split,
  input  logic               cfg_alt,
  input  logic               sel_dram,
  input  logic               sel_reg,
  input  logic               odt_in,
  input  logic               cke_in,
  input  logic [NUM_CH-1:0]  d_in,
  output logic [NUM_CH-1:0]  q_a,
  output logic [NUM_DUP-1:0] q_b,
  output logic               cs_a,
  output logic               cs_b,
  output logic               odt_a,
  output logic               odt_b,
  output logic               cke_a,
  output logic               cke_b
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned NUM_CTL = 3;
  localparam int unsigned IDX_CS  = 0;
  localparam int unsigned IDX_ODT = 1;
  localparam int unsigned IDX_CKE = 2;

  layout_e             layout;
  logic                rst_sync_n;
  logic [NUM_CH-1:0]   d_sel;
  logic                odt_sel;
  logic                cke_sel;
  logic                dup_en;
  logic                data_load;
  logic [NUM_CH-1:0]   data_r;
  logic [NUM_CTL-1:0]  ctl_d;
  logic [NUM_CTL-1:0]  ctl_r;
  logic [NUM_CTL-1:0]  ctl_a;
  logic [NUM_CTL-1:0]  ctl_b;

  assign layout = decode_layout(cfg_split, cfg_alt);

  cfgbuf_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfgbuf_route #(
    .NUM_CH     (NUM_CH),
    .NUM_DUP    (NUM_DUP),
    .ODT_ALT_CH (ODT_ALT_CH),
    .CKE_ALT_CH (CKE_ALT_CH)
  ) i_route (
    .layout  (layout),
    .d_in    (d_in),
    .odt_in  (odt_in),
    .cke_in  (cke_in),
    .d_sel   (d_sel),
    .odt_sel (odt_sel),
    .cke_sel (cke_sel),
    .dup_en  (dup_en)
  );

  // Data capture is enabled unless both selects are high.
  assign data_load = ~(sel_dram & sel_reg);

  cfgbuf_bank #(.WIDTH(NUM_CH)) i_data_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (data_load),
    .d     (d_sel),
    .q     (data_r)
  );

  always_comb begin
    ctl_d          = '0;
    ctl_d[IDX_CS]  = sel_dram;
    ctl_d[IDX_ODT] = odt_sel;
    ctl_d[IDX_CKE] = cke_sel;
  end

  cfgbuf_bank #(.WIDTH(NUM_CTL)) i_ctl_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (1'b1),
    .d     (ctl_d),
    .q     (ctl_r)
  );

  cfgbuf_fanout #(
    .NUM_CH  (NUM_CH),
    .NUM_DUP (NUM_DUP),
    .NUM_CTL (NUM_CTL)
  ) i_fanout (
    .dup_en (dup_en),
    .data_r (data_r),
    .ctl_r  (ctl_r),
    .data_a (q_a),
    .data_b (q_b),
    .ctl_a  (ctl_a),
    .ctl_b  (ctl_b)
  );

  assign cs_a  = ctl_a[IDX_CS];
  assign cs_b  = ctl_b[IDX_CS];
  assign odt_a = ctl_a[IDX_ODT];
  assign odt_b = ctl_b[IDX_ODT];
  assign cke_a = ctl_a[IDX_CKE];
  assign cke_b = ctl_b[IDX_CKE];
endmodule

// File: rtl/cfgbuf_chk.sv
module cfgbuf_chk #(
  parameter int unsigned NUM_CH      = 25,
  parameter int unsigned NUM_DUP     = 14,
  parameter int unsigned ODT_ALT_CH  = 11,
  parameter int unsigned CKE_ALT_CH  = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_split,
  input logic               cfg_alt,
  input logic               sel_dram,
  input logic               sel_reg,
  input logic               odt_in,
  input logic               cke_in,
  input logic [NUM_CH-1:0]  d_in,
  input logic [NUM_CH-1:0]  q_a,
  input logic [NUM_DUP-1:0] q_b,
  input logic               cs_a,
  input logic               cs_b,
  input logic               odt_a,
  input logic               odt_b,
  input logic               cke_a,
  input logic               cke_b
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [3:0] LIM = 4'(SYNC_STAGES + 1);

  logic [3:0] rel_cnt;
  logic       released;
  logic       all_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rel_cnt <= '0;
    else if (rel_cnt != LIM) rel_cnt <= rel_cnt + 4'd1;
  end

  assign released = (rel_cnt == LIM);
  assign all_low  = (q_a == '0) && (q_b == '0) && !cs_a && !cs_b &&
                    !odt_a && !odt_b && !cke_a && !cke_b;

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> all_low);

  assert_release_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !released |-> all_low);

  assert_hold_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_dram && sel_reg) |=> ($stable(q_a) && $stable(q_b)));

  assert_ctl_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (released && !$past(cfg_split && cfg_alt)) |->
      (cs_a == $past(sel_dram) && odt_a == $past(odt_in) && cke_a == $past(cke_in)));

  assert_wide_b_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_split |-> (q_b == '0 && !cs_b && !odt_b && !cke_b));

  assert_split_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_split |-> (q_b == q_a[NUM_DUP-1:0] && cs_b == cs_a &&
                   odt_b == odt_a && cke_b == cke_a && q_a[NUM_CH-1:NUM_DUP] == '0));

  assert_alt_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (released && $past(cfg_split && cfg_alt)) |->
      (odt_a == $past(d_in[ODT_ALT_CH-1]) && cke_a == $past(d_in[CKE_ALT_CH-1]) &&
       !q_a[ODT_ALT_CH-1] && !q_a[CKE_ALT_CH-1]));
endmodule

bind cfgbuf cfgbuf_chk #(
  .NUM_CH      (NUM_CH),
  .NUM_DUP     (NUM_DUP),
  .ODT_ALT_CH  (ODT_ALT_CH),
  .CKE_ALT_CH  (CKE_ALT_CH),
  .SYNC_STAGES (SYNC_STAGES)
) i_cfgbuf_chk (.*);

// File: tb/test_cfgbuf.sv
module test_cfgbuf;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH  = 25;
  localparam int NDUP = 14;
  localparam int VW   = NCH + NDUP + 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b1;
  logic            cfg_split = 1'b0;
  logic            cfg_alt = 1'b0;
  logic            sel_dram = 1'b0;
  logic            sel_reg = 1'b0;
  logic            odt_in = 1'b0;
  logic            cke_in = 1'b0;
  logic [NCH-1:0]  d_in = '0;
  logic [NCH-1:0]  q_a;
  logic [NDUP-1:0] q_b;
  logic            cs_a, cs_b, odt_a, odt_b, cke_a, cke_b;

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase_req = "R1";

  // Behavioural reference state.
  logic [NCH-1:0] m_data = '0;
  logic           m_cs = 1'b0, m_odt = 1'b0, m_cke = 1'b0;
  int             m_edges = 0;

  always #2.5 clk = ~clk;

  cfgbuf i_cfgbuf (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_alt(cfg_alt),
    .sel_dram(sel_dram), .sel_reg(sel_reg), .odt_in(odt_in), .cke_in(cke_in),
    .d_in(d_in), .q_a(q_a), .q_b(q_b), .cs_a(cs_a), .cs_b(cs_b),
    .odt_a(odt_a), .odt_b(odt_b), .cke_a(cke_a), .cke_b(cke_b)
  );

  function automatic bit chan_on(int ch, bit sp, bit al);
    if (!sp) return !(ch == 1 || ch == 4 || ch == 7);
    if (!al) return (ch <= 14) && !(ch == 1 || ch == 4 || ch == 7);
    return (ch <= 13) && (ch != 7) && (ch != 11);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0; m_cs = 0; m_odt = 0; m_cke = 0; m_edges = 0;
    end else if (m_edges < 2) begin
      m_edges = m_edges + 1;
    end else begin
      m_cs = sel_dram;
      if (cfg_split && cfg_alt) begin
        m_odt = d_in[10];
        m_cke = d_in[13];
      end else begin
        m_odt = odt_in;
        m_cke = cke_in;
      end
      if (!(sel_dram && sel_reg)) m_data = d_in;
    end
  end

  function automatic logic [VW-1:0] expected();
    logic [NCH-1:0]  ea;
    logic [NDUP-1:0] eb;
    for (int ch = 1; ch <= NCH; ch++)
      ea[ch-1] = chan_on(ch, cfg_split, cfg_alt) ? m_data[ch-1] : 1'b0;
    eb = cfg_split ? ea[NDUP-1:0] : '0;
    return {ea, eb, m_cs, cfg_split & m_cs, m_odt, cfg_split & m_odt,
            m_cke, cfg_split & m_cke};
  endfunction

  function automatic logic [VW-1:0] actual();
    return {q_a, q_b, cs_a, cs_b, odt_a, odt_b, cke_a, cke_b};
  endfunction

  task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk) check(phase_req, actual(), expected());

  task automatic drive(logic [NCH-1:0] d, bit dr, bit rs, bit o, bit c);
    @(negedge clk);
    #1;
    d_in = d; sel_dram = dr; sel_reg = rs; odt_in = o; cke_in = c;
  endtask

  function automatic real rand_phase();
    int k = $urandom_range(0, 39);
    return (k < 20) ? 0.2 + 0.1 * k : 2.7 + 0.1 * (k - 20);
  endfunction

  task automatic inputs_low();
    d_in = '0; sel_dram = 0; sel_reg = 0; odt_in = 0; cke_in = 0;
  endtask

  // R1: reset at a random phase clears outputs without a clock edge.
  task automatic enter_reset();
    @(posedge clk);
    #(rand_phase());
    rst_n = 1'b0;
    #0.1;
    check("R1", actual(), '0);
    repeat (2) @(posedge clk);
  endtask

  task automatic leave_reset();
    inputs_low();
    @(posedge clk);
    #(rand_phase());
    rst_n = 1'b1;
  endtask

  task automatic set_layout(bit sp, bit al, string req);
    enter_reset();
    cfg_split = sp;
    cfg_alt   = al;
    leave_reset();
    phase_req = req;
    repeat (3) @(posedge clk);
  endtask

  task automatic traffic(int n, string req);
    phase_req = req;
    for (int i = 0; i < n; i++)
      drive(NCH'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [NCH-1:0] wide_mask;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #0.1;
    check("R1", actual(), '0);

    // R2: release at random phases; outputs stay low for two edges.
    for (int r = 0; r < 6; r++) begin
      phase_req = "R2";
      if (r != 0) enter_reset();
      leave_reset();
      d_in = '1; sel_dram = 1; sel_reg = 0; odt_in = 1; cke_in = 1;
      for (int e = 1; e <= 3; e++) begin
        @(posedge clk);
        @(negedge clk);
        #0.1;
        if (e < 3) check("R2", actual(), '0);
        else       check("R2", actual(), expected());
      end
    end

    // R2: a quiet release with low inputs keeps outputs low.
    enter_reset();
    leave_reset();
    phase_req = "R2";
    repeat (5) @(posedge clk);
    #0.1;
    check("R2", actual(), '0);

    // R3: selects low, data loads; channel n on bit n-1.
    for (int i = 0; i < 30; i++) drive(NCH'($urandom), 0, 1'($urandom), 0, 0);
    phase_req = "R3";
    drive(NCH'(1) << 7, 1, 0, 0, 0);
    @(negedge clk); #0.1;
    check("R3", {q_a, q_b, 6'b0}, {NCH'(1) << 7, NDUP'(0), 6'b0});
    // Explicit full-width sample of active bits in wide layout.
    drive('1, 0, 0, 0, 0);
    @(negedge clk); #0.1;
    wide_mask = '1;
    wide_mask[0] = 0; wide_mask[3] = 0; wide_mask[6] = 0;
    check("R6", {q_a, q_b, 6'b0}, {wide_mask, NDUP'(0), 6'b0});

    // R4: both selects high hold data while controls keep loading.
    phase_req = "R4";
    for (int i = 0; i < 30; i++)
      drive(NCH'($urandom), 1, 1, 1'($urandom), 1'($urandom));
    drive('0, 1, 1, 0, 0);
    @(negedge clk); #0.1;
    check("R4", {q_a, q_b, 6'b0}, {wide_mask, NDUP'(0), 6'b0});

    // R5: all select combinations; controls register each edge.
    phase_req = "R5";
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 4; k++)
        drive(NCH'($urandom), c[0], c[1], c[2], c[3]);
    drive('0, 1, 1, 1, 0);
    @(negedge clk); #0.1;
    check("R5", {cs_a, odt_a, cke_a}, {1'b1, 1'b1, 1'b0});

    // R6: wide layout with cfg_alt high behaves like wide.
    set_layout(0, 1, "R6");
    traffic(80, "R6");

    // R7: split mapping A.
    set_layout(1, 0, "R7");
    traffic(80, "R7");
    drive('1, 0, 0, 0, 0);
    @(negedge clk); #0.1;
    check("R7", {q_a, q_b}, {11'b0, 14'b11_1111_1011_0110, 14'b11_1111_1011_0110});

    // R8: split mapping B; odt_in and cke_in ignored.
    set_layout(1, 1, "R8");
    traffic(80, "R8");
    drive(NCH'(1) << 10, 0, 0, 0, 1);
    @(negedge clk); #0.1;
    check("R8", {odt_a, odt_b, cke_a, cke_b, q_a[10]}, 5'b11000);
    drive(NCH'(1) << 13, 0, 0, 1, 0);
    @(negedge clk); #0.1;
    check("R8", {odt_a, cke_a, cke_b, q_a[13]}, 4'b0110);

    // R1 again in split mapping B, at a random phase.
    enter_reset();
    check("R1", actual(), '0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule